// File: doc/BRIEF.md
# Wake Event Register Controller

This block gathers wake requests from up to a dozen sources: two ring indicators, keyboard, mouse, a specific-key detector, two fan tachometers and four general-purpose inputs. Each source has a sticky status bit. The bit records an event even when nothing is enabled. Software clears a status bit by writing a 1 to it. Each source also has an enable bit, and the block has one global enable. A source drives the shared active-low wake line only when its status bit, its enable bit and the global enable are all set.

The status and enable bits are kept on standby power. They clear only on the standby power-on reset. A main-power reset, including soft and hard resets, leaves them as they are. Each tachometer pin has a mode input. While that pin works as a plain GPIO, the matching status bit cannot become 1, and it is forced to 0.

The register port is byte-wide, with an address, a write strobe, write data and registered read data. The event detectors, the bus decoding and the open-drain pad sit outside this block.

Top module: `pme_wake_ctrl`

## Requirements
- R1: An event pulse on a live source sets its status bit at the next clock edge, whatever the state of its enable bit and of the global enable.
- R2: Writing a 1 to a status bit clears it. Writing a 0 leaves that bit unchanged.
- R3: If an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R4: The standby reset clears every status bit, every enable bit and the global enable, and holds wake_n high.
- R5: The main reset clears only the global enable and the read data. All status and enable bits keep their values, so wake_n is released.
- R6: wake_n goes low one cycle after some source has status=1, enable=1 and global enable=1. Otherwise wake_n is high.
- R7: A source whose enable bit is 0 still records events in its status bit but never pulls wake_n low.
- R8: Status bits 6 and 7 of group A belong to tachometer 1 and tachometer 2, with tach_mode[0] and tach_mode[1] respectively (1 = tach mode, 0 = GPIO mode). In GPIO mode the matching bit never sets, and changing a pin to GPIO mode clears its bit.
- R9: Reserved bits read as 0 and ignore writes. These are group A bit 0, enable bits 7:4 of group B, status bits 7:4 of group B, and control bits 7:1. Offset 0x0B and every unmapped offset read 0x00.
- R10: The register map is as follows. 0x0A is status A: bit1 ring 2, bit2 ring 1, bit3 keyboard, bit4 mouse, bit5 specific key, bit6 tach 1, bit7 tach 2. 0x09 is the enable register for group A, with the same bit layout. 0x08 holds status B (GP20–GP23 on bits 3:0). 0x0C holds enable B (GP20–GP23 on bits 3:0). 0x07 holds the global enable in bit 0. rd_data shows the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_stby | input | 1 | Standby power-on reset, synchronous, active high |
| rst_main | input | 1 | Main-power, soft or hard reset, synchronous, active high |
| addr | input | 8 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| evt_a | input | 8 | Event pulses for group A, in the status A bit layout |
| evt_b | input | 4 | Event pulses for GP20–GP23 |
| tach_mode | input | 2 | Mode per tachometer pin, 1 = tach mode |
| wake_n | output | 1 | Active-low wake request, registered |

## Verification
The bench uses the default parameters: 8-bit data and address, eight group A sources and four group B sources. This is enough to reach every reserved bit position, the two tachometer bits at the top of group A, and an unmapped address between the used offsets. A vector table drives writes, event pulses and read-back checks across both groups. Directed tests then cover wake gating by single sources, the collision between an event and a clear, survival across the main reset, the tachometer mode changes and the standby reset.

// File: rtl/pme_pkg.sv
package pme_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STS_A,
    SEL_EN_A,
    SEL_STS_B,
    SEL_EN_B
  } pme_sel_e;
endpackage

// File: rtl/pme_sticky_bank.sv
module pme_sticky_bank #(
  parameter int           W    = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] park_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_mask;

  always_comb clr_mask = wr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= ((q_o & ~clr_mask) | evt_i) & LIVE & ~park_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    if (LIVE[i]) begin : g_live
      // R1
      evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i[i] && !park_i[i]) |=> q_o[i]);
      // R2
      w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[i] && !evt_i[i]) |=> !q_o[i]);
      // R2
      w0_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (q_o[i] && !(wr_i && wdata_i[i]) && !park_i[i]) |=> q_o[i]);
      // R8
      park_clear_chk: assert property (@(posedge clk) disable iff (rst)
        park_i[i] |=> !q_o[i]);
    end
  end
endmodule

// File: rtl/pme_en_bank.sv
module pme_en_bank #(
  parameter int           W    = 8,
  parameter logic [W-1:0] LIVE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (wr_i) q_o <= wdata_i & LIVE;
  end

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/pme_wake_gate.sv
module pme_wake_gate #(
  parameter int WA = 8,
  parameter int WB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WA-1:0] sts_a_i,
  input  logic [WA-1:0] en_a_i,
  input  logic [WB-1:0] sts_b_i,
  input  logic [WB-1:0] en_b_i,
  input  logic          gen_i,
  output logic          wake_n_o
);
  logic any_req;

  always_comb any_req = (|(sts_a_i & en_a_i)) | (|(sts_b_i & en_b_i));

  always_ff @(posedge clk) begin
    if (rst) wake_n_o <= 1'b1;
    else     wake_n_o <= ~(any_req & gen_i);
  end

  // R6
  gen_off_release_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_i |=> wake_n_o);
  // R7
  no_enabled_src_chk: assert property (@(posedge clk) disable iff (rst)
    (en_a_i == '0 && en_b_i == '0) |=> wake_n_o);
endmodule

// File: rtl/pme_wake_ctrl.sv
module pme_wake_ctrl #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                GRP_B_W   = 4,
  parameter logic [ADDR_W-1:0] OFF_CTRL  = 8'h07,
  parameter logic [ADDR_W-1:0] OFF_STS_B = 8'h08,
  parameter logic [ADDR_W-1:0] OFF_EN_A  = 8'h09,
  parameter logic [ADDR_W-1:0] OFF_STS_A = 8'h0A,
  parameter logic [ADDR_W-1:0] OFF_EN_B  = 8'h0C
) (
  input  logic               clk,
  input  logic               rst_stby,
  input  logic               rst_main,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [DATA_W-1:0]  evt_a,
  input  logic [GRP_B_W-1:0] evt_b,
  input  logic [1:0]         tach_mode,
  output logic               wake_n
);
  import pme_pkg::*;

  localparam logic [DATA_W-1:0]  LIVE_A = {{(DATA_W-1){1'b1}}, 1'b0};
  localparam logic [GRP_B_W-1:0] LIVE_B = '1;

  pme_sel_e           sel;
  logic [DATA_W-1:0]  sts_a, en_a, park_a, rd_nxt;
  logic [GRP_B_W-1:0] sts_b, en_b;
  logic               gen_q;
  logic               rst_any;

  always_comb rst_any = rst_stby | rst_main;

  always_comb begin
    if      (addr == OFF_CTRL)  sel = SEL_CTRL;
    else if (addr == OFF_STS_A) sel = SEL_STS_A;
    else if (addr == OFF_EN_A)  sel = SEL_EN_A;
    else if (addr == OFF_STS_B) sel = SEL_STS_B;
    else if (addr == OFF_EN_B)  sel = SEL_EN_B;
    else                        sel = SEL_NONE;
  end

  always_comb begin
    park_a = '0;
    park_a[DATA_W-1 -: 2] = ~{tach_mode[1], tach_mode[0]};
  end

  pme_sticky_bank #(.W(DATA_W), .LIVE(LIVE_A)) u_sts_a (
    .clk(clk), .rst(rst_stby), .evt_i(evt_a), .park_i(park_a),
    .wr_i(wr_en && sel == SEL_STS_A), .wdata_i(wr_data), .q_o(sts_a));

  pme_sticky_bank #(.W(GRP_B_W), .LIVE(LIVE_B)) u_sts_b (
    .clk(clk), .rst(rst_stby), .evt_i(evt_b), .park_i('0),
    .wr_i(wr_en && sel == SEL_STS_B), .wdata_i(wr_data[GRP_B_W-1:0]),
    .q_o(sts_b));

  pme_en_bank #(.W(DATA_W), .LIVE(LIVE_A)) u_en_a (
    .clk(clk), .rst(rst_stby), .wr_i(wr_en && sel == SEL_EN_A),
    .wdata_i(wr_data), .q_o(en_a));

  pme_en_bank #(.W(GRP_B_W), .LIVE(LIVE_B)) u_en_b (
    .clk(clk), .rst(rst_stby), .wr_i(wr_en && sel == SEL_EN_B),
    .wdata_i(wr_data[GRP_B_W-1:0]), .q_o(en_b));

  always_ff @(posedge clk) begin
    if (rst_any)                        gen_q <= 1'b0;
    else if (wr_en && sel == SEL_CTRL)  gen_q <= wr_data[0];
  end

  pme_wake_gate #(.WA(DATA_W), .WB(GRP_B_W)) u_gate (
    .clk(clk), .rst(rst_stby), .sts_a_i(sts_a), .en_a_i(en_a),
    .sts_b_i(sts_b), .en_b_i(en_b), .gen_i(gen_q), .wake_n_o(wake_n));

  always_comb begin
    rd_nxt = '0;
    case (sel)
      SEL_CTRL:  rd_nxt[0] = gen_q;
      SEL_STS_A: rd_nxt = sts_a;
      SEL_EN_A:  rd_nxt = en_a;
      SEL_STS_B: rd_nxt[GRP_B_W-1:0] = sts_b;
      SEL_EN_B:  rd_nxt[GRP_B_W-1:0] = en_b;
      default:   rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) rd_data <= '0;
    else         rd_data <= rd_nxt;
  end

  // R5
  main_rst_gen_chk: assert property (@(posedge clk) disable iff (rst_stby)
    rst_main |=> (gen_q == 1'b0));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst_any)
    (sel == SEL_NONE) |=> (rd_data == '0));
  // R4
  stby_release_chk: assert property (@(posedge clk)
    rst_stby |=> (wake_n && sts_a == '0 && en_b == '0));
endmodule

// File: tb/tb_pme_wake_ctrl.sv
`timescale 1ns/1ps
module tb_pme_wake_ctrl;
  logic       clk = 1'b0;
  logic       rst_stby, rst_main, wr_en, wake_n;
  logic [7:0] addr, wr_data, rd_data, evt_a;
  logic [3:0] evt_b;
  logic [1:0] tach_mode;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pme_wake_ctrl dut (
    .clk(clk), .rst_stby(rst_stby), .rst_main(rst_main), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .evt_a(evt_a),
    .evt_b(evt_b), .tach_mode(tach_mode), .wake_n(wake_n));

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EA = 2'd2, OP_EB = 2'd3;
  localparam int NV = 19;
  // {op, addr, data, expected read}
  localparam logic [25:0] VEC [NV] = '{
    {OP_RD, 8'h0A, 8'h00, 8'h00},   // R4 status A clear after reset
    {OP_EA, 8'h00, 8'hFF, 8'h00},
    {OP_RD, 8'h0A, 8'h00, 8'hFE},   // R1 R9 bit0 reserved
    {OP_WR, 8'h0A, 8'h0F, 8'h00},
    {OP_RD, 8'h0A, 8'h00, 8'hF0},   // R2 ones clear
    {OP_WR, 8'h0A, 8'h00, 8'h00},
    {OP_RD, 8'h0A, 8'h00, 8'hF0},   // R2 zeros keep
    {OP_EB, 8'h00, 8'h05, 8'h00},
    {OP_RD, 8'h08, 8'h00, 8'h05},   // R1 R10 group B
    {OP_EB, 8'h00, 8'h0A, 8'h00},
    {OP_RD, 8'h08, 8'h00, 8'h0F},   // R1
    {OP_WR, 8'h0C, 8'hFF, 8'h00},
    {OP_RD, 8'h0C, 8'h00, 8'h0F},   // R9 R10 enable B
    {OP_WR, 8'h09, 8'hFF, 8'h00},
    {OP_RD, 8'h09, 8'h00, 8'hFE},   // R9 R10 enable A
    {OP_WR, 8'h0B, 8'hFF, 8'h00},
    {OP_RD, 8'h0B, 8'h00, 8'h00},   // R9 reserved offset
    {OP_WR, 8'h07, 8'hFF, 8'h00},
    {OP_RD, 8'h07, 8'h00, 8'h01}    // R9 R10 control
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    tick();
    check(req, rd_data, exp);
  endtask

  task automatic do_ev(input logic [7:0] a, input logic [3:0] b);
    evt_a = a; evt_b = b;
    tick();
    evt_a = 8'h00; evt_b = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_stby = 1'b1; rst_main = 1'b1; wr_en = 1'b0; addr = 8'h00;
    wr_data = 8'h00; evt_a = 8'h00; evt_b = 4'h0; tach_mode = 2'b11;
    repeat (3) tick();
    rst_stby = 1'b0; rst_main = 1'b0;
    check("R4 wake_n", {7'd0, wake_n}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][25:24])
        OP_WR: do_wr(VEC[i][23:16], VEC[i][15:8]);
        OP_RD: do_rd("R10 table", VEC[i][23:16], VEC[i][7:0]);
        OP_EA: do_ev(VEC[i][15:8], 4'h0);
        default: do_ev(8'h00, VEC[i][11:8]);
      endcase
    end
    do_rd("R9 unmapped", 8'h3F, 8'h00);

    tick();
    check("R6 wake asserted", {7'd0, wake_n}, 8'h00);

    do_wr(8'h0A, 8'hFF); do_wr(8'h08, 8'hFF); do_wr(8'h09, 8'h10);
    tick(); tick();
    check("R6 wake released", {7'd0, wake_n}, 8'h01);

    do_ev(8'h08, 4'h0); tick();
    check("R7 disabled source", {7'd0, wake_n}, 8'h01);
    do_rd("R7 status recorded", 8'h0A, 8'h08);

    do_ev(8'h10, 4'h0); tick();
    check("R6 enabled source", {7'd0, wake_n}, 8'h00);
    do_wr(8'h07, 8'h00); tick();
    check("R6 global off", {7'd0, wake_n}, 8'h01);
    do_wr(8'h07, 8'h01); tick();
    check("R6 global on", {7'd0, wake_n}, 8'h00);

    addr = 8'h0A; wr_data = 8'h18; wr_en = 1'b1; evt_a = 8'h08;
    tick();
    wr_en = 1'b0; evt_a = 8'h00;
    do_rd("R3 set wins", 8'h0A, 8'h08);

    do_ev(8'h10, 4'h0);
    rst_main = 1'b1; tick(); rst_main = 1'b0;
    do_rd("R5 status kept", 8'h0A, 8'h18);
    do_rd("R5 enable kept", 8'h09, 8'h10);
    do_rd("R5 global cleared", 8'h07, 8'h00);
    check("R5 wake released", {7'd0, wake_n}, 8'h01);

    tach_mode = 2'b10;
    do_ev(8'hC0, 4'h0);
    do_rd("R8 gpio mode masks", 8'h0A, 8'h98);
    tach_mode = 2'b11;
    do_ev(8'h40, 4'h0);
    do_rd("R8 tach mode sets", 8'h0A, 8'hD8);
    tach_mode = 2'b01;
    tick();
    do_rd("R8 switch clears", 8'h0A, 8'h58);

    tach_mode = 2'b11;
    rst_stby = 1'b1; tick(); rst_stby = 1'b0;
    do_rd("R4 status A", 8'h0A, 8'h00);
    do_rd("R4 enable A", 8'h09, 8'h00);
    do_rd("R4 enable B", 8'h0C, 8'h00);
    check("R4 wake_n", {7'd0, wake_n}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule